// File: doc/BRIEF.md
# Timer Tick Prescaler with Base-Clock Select

This block produces the count-enable pulse for an 8-bit timer. It has two base sources. The first is every cycle of the system clock. The second is the rising edges of a slow external oscillator tick, such as a 32.768 kHz watch crystal, which lets the timer act as a real-time counter.

A free-running 10-bit prescaler counter advances once per base event. A 3-bit select field picks the output:
- no ticks at all,
- the undivided base, or
- the base divided by 8, 32, 64, 128, 256 or 1024.

A one-cycle software clear pulse zeroes the prescaler so that the phase of the next divided tick is known.

The output `tick_o` is registered. A tick is asserted for one clock cycle, in the cycle after the base event that produced it. The external tick is brought into the `clk_i` domain through a two-flop synchronizer and a rising-edge detector.

Top module: `tmr_prescaler`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0. Reset zeroes the prescaler, so with `clk_sel_i`=2 the first tick appears on the 8th clock edge after reset is released.
- R2: With `clk_sel_i`=0 (stop), `tick_o` stays 0.
- R3: With `clk_sel_i`=1, `tick_o` is 1 in the cycle after every base event. This includes the cycle in which `pre_clr_i` is high. In system mode, a base event happens on every cycle.
- R4: The codes 2, 3, 4, 5, 6 and 7 divide the base by 8, 32, 64, 128, 256 and 1024 in that order. A divided tick fires when the low log2(divisor) bits of the prescaler are all ones at a base event.
- R5: A divided tick (codes 2 to 7) lasts exactly one cycle.
- R6: With `ext_sel_i`=1, each rising edge of `ext_tick_i` is one base event, after a two-flop synchronizer. System clock cycles alone do not advance the prescaler.
- R7: When `pre_clr_i` is high, the prescaler is zeroed on that edge and no divided tick comes from that cycle. The next divided tick follows exactly one divisor's worth of base events later.
- R8: A change of `clk_sel_i` acts on the next edge and does not reset the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_sel_i | input | 1 | 1 selects the external tick as base, 0 selects the system clock |
| ext_tick_i | input | 1 | Slow external oscillator tick, asynchronous to `clk_i` |
| clk_sel_i | input | 3 | 0 stop, 1 undivided, 2 /8, 3 /32, 4 /64, 5 /128, 6 /256, 7 /1024 |
| pre_clr_i | input | 1 | One-cycle prescaler clear |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The failure modes show up at the port as follows:
- **Stuck or skipped prescaler bit:** the tick count over a window changes. This is visible within one period of the selected divisor, which is at most 1024 base events.
- **Clear that misses or that leaks a tick:** the phase of the first tick after the clear moves, or a tick appears in the cycle after the clear. Both are seen within eight cycles in /8 mode.
- **Select change that resets the counter:** the first tick after the change arrives late by the count already reached.
- **Broken synchronizer or edge detector:** the tick count per external edge in external mode is wrong, or ticks appear while the external input is idle.

// File: rtl/tmr_pre_pkg.sv
package tmr_pre_pkg;
  localparam int SEL_W = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP    = 3'd0,
    SEL_DIV1    = 3'd1,
    SEL_DIV8    = 3'd2,
    SEL_DIV32   = 3'd3,
    SEL_DIV64   = 3'd4,
    SEL_DIV128  = 3'd5,
    SEL_DIV256  = 3'd6,
    SEL_DIV1024 = 3'd7
  } clk_sel_e;

  // log2 of the divisor for each divided code
  function automatic int tap_shift(input int code);
    case (code)
      2: return 3;
      3: return 5;
      4: return 6;
      5: return 7;
      6: return 8;
      7: return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ext_tick_sync.sv
module ext_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[LAST-1:0], tick_i};
  end

  assign rise_o = sync_q[LAST-1] & ~sync_q[LAST];

  assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pre_counter.sv
module pre_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(cnt_o));
  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/tap_select.sv
module tap_select
  import tmr_pre_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [NUM_SEL-1:0] tap_vec;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
    if (g == int'(SEL_STOP)) begin : g_stop
      assign tap_vec[g] = 1'b0;
    end else if (g == int'(SEL_DIV1)) begin : g_div1
      assign tap_vec[g] = adv_i;
    end else begin : g_div
      localparam int SH = tap_shift(g);
      // tap fires on the event that wraps the low SH bits to zero
      assign tap_vec[g] = adv_i & ~clr_i & (&cnt_i[SH-1:0]);
    end
  end

  assign tick_o = tap_vec[sel_i];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pre_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic             ext_tick_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             pre_clr_i,
  output logic             tick_o
);
  logic             ext_rise;
  logic             base_adv;
  logic [CNT_W-1:0] cnt;
  logic             tick_d;
  logic             tick_q;

  ext_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ext_tick_i),
    .rise_o (ext_rise)
  );

  assign base_adv = ext_sel_i ? ext_rise : 1'b1;

  pre_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (base_adv),
    .clr_i  (pre_clr_i),
    .cnt_o  (cnt)
  );

  tap_select #(.CNT_W(CNT_W)) u_tap (
    .cnt_i  (cnt),
    .adv_i  (base_adv),
    .clr_i  (pre_clr_i),
    .sel_i  (clk_sel_i),
    .tick_o (tick_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;

  assert_stop_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == SEL_STOP) |=> !tick_o);
  assert_div1_every_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == SEL_DIV1 && !ext_sel_i) |=> tick_o);
  assert_div_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(clk_sel_i) >= SEL_DIV8 && clk_sel_i >= SEL_DIV8) |=> !tick_o);
  assert_clr_no_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_clr_i && clk_sel_i >= SEL_DIV8) |=> !tick_o);
endmodule

// File: tb/tb_tmr_prescaler.sv
`timescale 1ns/1ps
module tb_tmr_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_sel = 1'b0;
  logic       ext_tick = 1'b0;
  logic [2:0] sel = 3'd2;
  logic       clr = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_prescaler dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_sel_i  (ext_sel),
    .ext_tick_i (ext_tick),
    .clk_sel_i  (sel),
    .pre_clr_i  (clr),
    .tick_o     (tick)
  );

  typedef struct packed {
    logic        ext;
    logic [2:0]  code;
    int unsigned len;
    int unsigned exp;
  } vec_t;

  // system: len = cycles after clear; external: len = rising edges
  localparam vec_t VEC [14] = '{
    '{1'b0, 3'd0, 2048, 0},
    '{1'b0, 3'd1, 2048, 2048},
    '{1'b0, 3'd2, 2048, 256},
    '{1'b0, 3'd3, 2048, 64},
    '{1'b0, 3'd4, 2048, 32},
    '{1'b0, 3'd5, 2048, 16},
    '{1'b0, 3'd6, 2048, 8},
    '{1'b0, 3'd7, 2048, 2},
    '{1'b1, 3'd1, 64, 64},
    '{1'b1, 3'd2, 64, 8},
    '{1'b1, 3'd3, 64, 2},
    '{1'b1, 3'd4, 64, 1},
    '{1'b1, 3'd5, 64, 0},
    '{1'b1, 3'd0, 64, 0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_cnt(inout int c, inout int dbl, inout bit prev);
    @(negedge clk);
    if (tick) c++;
    if (tick && prev) dbl++;
    prev = tick;
  endtask

  task automatic run_vec(input vec_t v, output int c, output int dbl);
    bit prev = 1'b0;
    c = 0; dbl = 0;
    ext_sel = v.ext;
    ext_tick = 1'b0;
    repeat (4) @(negedge clk);
    sel = v.code;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    if (!v.ext) begin
      for (int i = 0; i < int'(v.len); i++) step_cnt(c, dbl, prev);
    end else begin
      for (int r = 0; r < int'(v.len); r++) begin
        ext_tick = 1'b1;
        repeat (3) step_cnt(c, dbl, prev);
        ext_tick = 1'b0;
        repeat (3) step_cnt(c, dbl, prev);
      end
      repeat (8) step_cnt(c, dbl, prev);
    end
  endtask

  task automatic first_tick(input int start, input int lim, output int idx);
    idx = -1;
    for (int i = start; i <= lim; i++) begin
      @(negedge clk);
      if (tick && idx < 0) idx = i;
    end
  endtask

  initial begin
    int c, dbl, idx;
    // R1: reset state and prescaler zeroed by reset
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    first_tick(1, 12, idx);
    chk(idx == 8, "R1 first /8 tick after reset", idx, 8);

    // table walk: R2 R3 R4 R6
    foreach (VEC[k]) begin
      run_vec(VEC[k], c, dbl);
      chk(c == int'(VEC[k].exp),
          VEC[k].ext ? "R6 external base tick count" :
          (VEC[k].code == 0 ? "R2 stop tick count" :
           (VEC[k].code == 1 ? "R3 undivided tick count" : "R4 divided tick count")),
          c, int'(VEC[k].exp));
      if (VEC[k].code >= 2)
        chk(dbl == 0, "R5 divided tick single cycle", dbl, 0);
    end

    // R7: clear on the edge where a /8 tick was due
    ext_sel = 1'b0;
    sel = 3'd2; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (7) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0, "R7 no divided tick on clear", int'(tick), 0);
    clr = 1'b0;
    first_tick(1, 12, idx);
    chk(idx == 8, "R7 phase after clear", idx, 8);

    // R3: undivided tick not suppressed by clear
    sel = 3'd1; clr = 1'b1;
    @(negedge clk);
    chk(tick == 1'b1, "R3 undivided tick during clear", int'(tick), 1);
    clr = 1'b0;

    // R8: select change keeps prescaler count
    sel = 3'd7; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (4) @(negedge clk);
    sel = 3'd2;
    first_tick(5, 16, idx);
    chk(idx == 8, "R8 no counter reset on select change", idx, 8);

    // R8: select acts on next edge
    sel = 3'd0;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R8 stop before change", int'(tick), 0);
    sel = 3'd1;
    @(negedge clk);
    chk(tick == 1'b1, "R8 undivided one edge after change", int'(tick), 1);
    sel = 3'd0;
    @(negedge clk);
    chk(tick == 1'b0, "R8 stop one edge after change", int'(tick), 0);

    // R6: external mode ignores system clock cycles
    ext_sel = 1'b1; ext_tick = 1'b0; sel = 3'd1;
    c = 0;
    repeat (60) begin
      @(negedge clk);
      if (tick) c++;
    end
    chk(c == 0, "R6 idle external source gives no ticks", c, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule